// File: doc/BRIEF.md
# Condition Register Operation Unit

This unit carries out the instructions that read or rewrite a 32-bit condition register made of eight 4-bit fields. It does four kinds of work:

- a masked move of general-register bits into selected fields;
- a move of the register, or of chosen fields, into a 64-bit general result;
- a copy of one field onto another;
- a two-input boolean function applied to two single bits, with the answer written to a third bit.

Field and bit numbers taken from the instruction count from the most significant end of the register.

One set of inputs is accepted per clock. The opcode and instruction word come in with a qualifier, together with the low 32 bits of the general operand and the current register value. All results appear one clock later on a single output register stage. The opcode and instruction word come out on that same stage. Each result has its own write flag, which feeds the writeback request. A flag rises only for an operation that really produces that result, so other operations never cause a spurious register-file write.

The output stage has two conditions, and there is no other sequencing. The idle condition holds after reset or after a clock with the input qualifier low. The issued condition holds after a clock with the qualifier high. From either condition, the qualifier at the next edge decides which condition follows.

Top module: `crunit_top`

## Requirements
- R1: While reset (active-low, synchronous) is applied, `out_vld`, `res_wr` and `cr_wr` are low at the following edge.
- R2: One clock after `in_vld` is high, `out_vld` is high and `out_op`/`out_insn` equal the opcode and instruction word that were presented.
- R3: Opcode 1 (masked move in): the mask is insn[19:12]. Mask bit k set replaces packed field k (bits 4k+3..4k) with the same bits of `gpr_in`, and a clear mask bit keeps the field of `cr_in`. `cr_wr`=1 and `res_wr`=0.
- R4: Opcode 2 with insn[20]=0 (whole move out): `res_out` is `cr_in` zero-extended to 64 bits, `res_wr`=1, `cr_wr`=0 and `cr_out`=`cr_in`.
- R5: Opcode 2 with insn[20]=1 (field move out): packed field k of `res_out` is copied from `cr_in` when insn[12+k] is set and is zero otherwise. The upper 32 bits are zero and `res_wr`=1.
- R6: Opcode 3 (field copy): the destination number is insn[25:23] and the source number is insn[20:18]. Packed field 7-dest takes the value of packed field 7-src, all other fields keep their value, and `cr_wr`=1.
- R7: Opcode 4 (bit boolean): BT=insn[25:21], BA=insn[20:16], BB=insn[15:11] and the truth table is insn[9:6]. With a=cr_in[31-BA] and b=cr_in[31-BB], packed bit 31-BT becomes insn[6+2a+b], the other 31 bits are unchanged, and `cr_wr`=1.
- R8: Opcodes 0, 5, 6 and 7, and any clock with `in_vld` low, give `res_wr`=0 and `cr_wr`=0 one clock later. For opcodes 0, 5, 6 and 7, `cr_out` equals `cr_in` and `res_out` is zero.
- R9: `res_wr` and `cr_wr` are never high in the same clock, and `res_wr`=0 for every opcode other than 2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| in_vld | input | 1 | Input operation is valid |
| op_in | input | 3 | Operation code |
| insn_in | input | 32 | Instruction word carrying the masks, indices and truth table |
| gpr_in | input | 32 | Low word of the general-purpose operand |
| cr_in | input | 32 | Current condition register |
| out_vld | output | 1 | Output stage holds an issued operation |
| out_op | output | 3 | Opcode passed through |
| out_insn | output | 32 | Instruction word passed through |
| res_out | output | 64 | General result |
| res_wr | output | 1 | General result write request |
| cr_out | output | 32 | Full condition register result |
| cr_wr | output | 1 | Condition register write request |

## Verification
On every clock the assertions check several properties. They check the one-clock passing of opcode and instruction word, and that both write flags stay quiet for idle cycles and unknown opcodes. They check that the two flags are never high together, the exact zero-extended whole-register move-out, and the unchanged register for an empty move-in mask. They also check that the bit boolean flips at most one bit. Only the bench's scenarios show the field-level results: which field a mask bit or a field number selects, the zeroing of unselected fields in the one-field move-out, and the truth table lookup at MSB-counted bit positions. The bench compares all of these against a behavioural model over directed corner cases and random operands.

// File: rtl/crunit_pkg.sv
`timescale 1ns/1ps
package crunit_pkg;
    localparam int NFLD = 8;
    localparam int FW   = 4;
    localparam int CRW  = NFLD * FW;
    localparam int XLEN = 64;
    localparam int IW   = 32;
    localparam int FSW  = $clog2(NFLD);
    localparam int BSW  = $clog2(CRW);

    // instruction field positions
    localparam int MASK_LSB = 12;
    localparam int ONEF_BIT = 20;
    localparam int DSTF_LSB = 23;
    localparam int SRCF_LSB = 18;
    localparam int BT_LSB   = 21;
    localparam int BA_LSB   = 16;
    localparam int BB_LSB   = 11;
    localparam int TT_LSB   = 6;

    typedef enum logic [2:0] {
        OPC_NOP   = 3'd0,
        OPC_MTCR  = 3'd1,
        OPC_MFCR  = 3'd2,
        OPC_FCOPY = 3'd3,
        OPC_BITOP = 3'd4
    } cr_op_e;
endpackage

// File: rtl/crunit_mtcr.sv
`timescale 1ns/1ps
module crunit_mtcr #(
    parameter int NFLD = 8,
    parameter int FW   = 4,
    localparam int CRW = NFLD * FW
) (
    input  logic [CRW-1:0]  cr_in,
    input  logic [CRW-1:0]  src,
    input  logic [NFLD-1:0] mask,
    output logic [CRW-1:0]  cr_res
);
    for (genvar g = 0; g < NFLD; g++) begin : g_fld
        assign cr_res[g*FW +: FW] = mask[g] ? src[g*FW +: FW] : cr_in[g*FW +: FW];
    end
endmodule

// File: rtl/crunit_mfcr.sv
`timescale 1ns/1ps
module crunit_mfcr #(
    parameter int NFLD = 8,
    parameter int FW   = 4,
    parameter int XLEN = 64,
    localparam int CRW = NFLD * FW
) (
    input  logic [CRW-1:0]  cr_in,
    input  logic [NFLD-1:0] mask,
    input  logic            one_fld,
    output logic [XLEN-1:0] res
);
    logic [CRW-1:0] picked;

    for (genvar g = 0; g < NFLD; g++) begin : g_fld
        assign picked[g*FW +: FW] = (!one_fld || mask[g]) ? cr_in[g*FW +: FW] : '0;
    end

    assign res = {{(XLEN-CRW){1'b0}}, picked};
endmodule

// File: rtl/crunit_fcopy.sv
`timescale 1ns/1ps
module crunit_fcopy #(
    parameter int NFLD = 8,
    parameter int FW   = 4,
    localparam int CRW = NFLD * FW,
    localparam int FSW = $clog2(NFLD)
) (
    input  logic [CRW-1:0] cr_in,
    input  logic [FSW-1:0] dst_num,
    input  logic [FSW-1:0] src_num,
    output logic [CRW-1:0] cr_res
);
    logic [FW-1:0] src_fld;

    // numbers count from the most significant field
    always_comb begin
        src_fld = '0;
        for (int k = 0; k < NFLD; k++) begin
            if (src_num == FSW'(NFLD-1-k)) src_fld = cr_in[k*FW +: FW];
        end
    end

    for (genvar g = 0; g < NFLD; g++) begin : g_fld
        localparam logic [FSW-1:0] MYNUM = FSW'(NFLD-1-g);
        assign cr_res[g*FW +: FW] = (dst_num == MYNUM) ? src_fld : cr_in[g*FW +: FW];
    end
endmodule

// File: rtl/crunit_bitop.sv
`timescale 1ns/1ps
module crunit_bitop #(
    parameter int CRW = 32,
    localparam int BSW = $clog2(CRW)
) (
    input  logic [CRW-1:0] cr_in,
    input  logic [BSW-1:0] bt,
    input  logic [BSW-1:0] ba,
    input  logic [BSW-1:0] bb,
    input  logic [3:0]     tt,
    output logic [CRW-1:0] cr_res
);
    logic bit_a;
    logic bit_b;
    logic new_bit;

    always_comb begin
        bit_a = 1'b0;
        bit_b = 1'b0;
        for (int k = 0; k < CRW; k++) begin
            if (ba == BSW'(CRW-1-k)) bit_a = cr_in[k];
            if (bb == BSW'(CRW-1-k)) bit_b = cr_in[k];
        end
    end

    assign new_bit = tt[{bit_a, bit_b}];

    for (genvar g = 0; g < CRW; g++) begin : g_bit
        localparam logic [BSW-1:0] MYNUM = BSW'(CRW-1-g);
        assign cr_res[g] = (bt == MYNUM) ? new_bit : cr_in[g];
    end
endmodule

// File: rtl/crunit_top.sv
`timescale 1ns/1ps
module crunit_top
    import crunit_pkg::*;
(
    input  logic            clk,
    input  logic            rst_n,
    input  logic            in_vld,
    input  logic [2:0]      op_in,
    input  logic [IW-1:0]   insn_in,
    input  logic [CRW-1:0]  gpr_in,
    input  logic [CRW-1:0]  cr_in,
    output logic            out_vld,
    output logic [2:0]      out_op,
    output logic [IW-1:0]   out_insn,
    output logic [XLEN-1:0] res_out,
    output logic            res_wr,
    output logic [CRW-1:0]  cr_out,
    output logic            cr_wr
);
    cr_op_e         op_e;
    logic [CRW-1:0]  mt_cr, fc_cr, bo_cr;
    logic [XLEN-1:0] mf_res;
    logic [XLEN-1:0] nx_res;
    logic [CRW-1:0]  nx_cr;
    logic            nx_res_wr, nx_cr_wr;

    assign op_e = cr_op_e'(op_in);

    crunit_mtcr #(.NFLD(NFLD), .FW(FW)) u_mtcr (
        .cr_in  (cr_in),
        .src    (gpr_in),
        .mask   (insn_in[MASK_LSB +: NFLD]),
        .cr_res (mt_cr)
    );

    crunit_mfcr #(.NFLD(NFLD), .FW(FW), .XLEN(XLEN)) u_mfcr (
        .cr_in   (cr_in),
        .mask    (insn_in[MASK_LSB +: NFLD]),
        .one_fld (insn_in[ONEF_BIT]),
        .res     (mf_res)
    );

    crunit_fcopy #(.NFLD(NFLD), .FW(FW)) u_fcopy (
        .cr_in   (cr_in),
        .dst_num (insn_in[DSTF_LSB +: FSW]),
        .src_num (insn_in[SRCF_LSB +: FSW]),
        .cr_res  (fc_cr)
    );

    crunit_bitop #(.CRW(CRW)) u_bitop (
        .cr_in  (cr_in),
        .bt     (insn_in[BT_LSB +: BSW]),
        .ba     (insn_in[BA_LSB +: BSW]),
        .bb     (insn_in[BB_LSB +: BSW]),
        .tt     (insn_in[TT_LSB +: 4]),
        .cr_res (bo_cr)
    );

    // result selection and write-flag generation
    always_comb begin
        nx_res    = '0;
        nx_cr     = cr_in;
        nx_res_wr = 1'b0;
        nx_cr_wr  = 1'b0;
        unique case (op_e)
            OPC_MTCR: begin
                nx_cr    = mt_cr;
                nx_cr_wr = in_vld;
            end
            OPC_MFCR: begin
                nx_res    = mf_res;
                nx_res_wr = in_vld;
            end
            OPC_FCOPY: begin
                nx_cr    = fc_cr;
                nx_cr_wr = in_vld;
            end
            OPC_BITOP: begin
                nx_cr    = bo_cr;
                nx_cr_wr = in_vld;
            end
            default: ;
        endcase
    end

    // single output stage
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_vld  <= 1'b0;
            out_op   <= '0;
            out_insn <= '0;
            res_out  <= '0;
            res_wr   <= 1'b0;
            cr_out   <= '0;
            cr_wr    <= 1'b0;
        end else begin
            out_vld  <= in_vld;
            out_op   <= op_in;
            out_insn <= insn_in;
            res_out  <= nx_res;
            res_wr   <= nx_res_wr;
            cr_out   <= nx_cr;
            cr_wr    <= nx_cr_wr;
        end
    end
endmodule

// File: rtl/crunit_chk.sv
`timescale 1ns/1ps
module crunit_chk (
    input logic        clk,
    input logic        rst_n,
    input logic        in_vld,
    input logic [2:0]  op_in,
    input logic [31:0] insn_in,
    input logic [31:0] cr_in,
    input logic        out_vld,
    input logic [2:0]  out_op,
    input logic [31:0] out_insn,
    input logic [63:0] res_out,
    input logic        res_wr,
    input logic [31:0] cr_out,
    input logic        cr_wr
);
    logic unknown_op;
    assign unknown_op = (op_in == 3'd0) || (op_in > 3'd4);

    assert_ctx_pass_R2: assert property (@(posedge clk) disable iff (!rst_n)
        in_vld |=> out_vld && out_op == $past(op_in) && out_insn == $past(insn_in));

    assert_mtcr_empty_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op_in == 3'd1 && insn_in[19:12] == 8'h00) |=> cr_wr && cr_out == $past(cr_in));

    assert_mfcr_whole_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op_in == 3'd2 && !insn_in[20]) |=>
            res_wr && !cr_wr && res_out == {32'h0, $past(cr_in)});

    assert_bitop_single_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op_in == 3'd4) |=> cr_wr && $countones(cr_out ^ $past(cr_in)) <= 1);

    assert_idle_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        !in_vld |=> !out_vld && !res_wr && !cr_wr);

    assert_unknown_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && unknown_op) |=> !res_wr && !cr_wr && cr_out == $past(cr_in));

    assert_flag_excl_R9: assert property (@(posedge clk) disable iff (!rst_n)
        !(res_wr && cr_wr));

    assert_reswr_only_mfcr_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (in_vld && op_in != 3'd2) |=> !res_wr);
endmodule

bind crunit_top crunit_chk u_chk (.*);

// File: tb/tb_crunit_top.sv
`timescale 1ns/1ps
module tb_crunit_top;
    logic        clk = 1'b0;
    logic        rst_n;
    logic        in_vld;
    logic [2:0]  op_in;
    logic [31:0] insn_in;
    logic [31:0] gpr_in;
    logic [31:0] cr_in;
    logic        out_vld;
    logic [2:0]  out_op;
    logic [31:0] out_insn;
    logic [63:0] res_out;
    logic        res_wr;
    logic [31:0] cr_out;
    logic        cr_wr;

    int n_cmp = 0;
    int n_bad = 0;
    bit done = 0;

    always #4 clk = ~clk;

    crunit_top dut (.*);

    task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
        n_cmp++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    // behavioural reference model
    task automatic model(input logic [2:0] op, input logic [31:0] ins, input logic [31:0] g,
                         input logic [31:0] c, output logic [63:0] eres, output bit erw,
                         output logic [31:0] ecr, output bit ecw);
        eres = 64'h0; ecr = c; erw = 0; ecw = 0;
        case (op)
            3'd1: begin
                for (int b = 0; b < 32; b++) ecr[b] = ins[12 + b/4] ? g[b] : c[b];
                ecw = 1;
            end
            3'd2: begin
                for (int b = 0; b < 32; b++) eres[b] = (!ins[20] || ins[12 + b/4]) ? c[b] : 1'b0;
                erw = 1;
            end
            3'd3: begin
                int dpk, spk;
                dpk = 7 - int'(ins[25:23]);
                spk = 7 - int'(ins[20:18]);
                for (int j = 0; j < 4; j++) ecr[4*dpk + j] = c[4*spk + j];
                ecw = 1;
            end
            3'd4: begin
                int a, bb;
                a  = c[31 - int'(ins[20:16])];
                bb = c[31 - int'(ins[15:11])];
                ecr[31 - int'(ins[25:21])] = ins[6 + 2*a + bb];
                ecw = 1;
            end
            default: ;
        endcase
    endtask

    task automatic step(input bit v, input logic [2:0] op, input logic [31:0] ins,
                        input logic [31:0] g, input logic [31:0] c, input string tag);
        logic [63:0] eres; bit erw; logic [31:0] ecr; bit ecw;
        @(negedge clk);
        in_vld = v; op_in = op; insn_in = ins; gpr_in = g; cr_in = c;
        model(op, ins, g, c, eres, erw, ecr, ecw);
        @(posedge clk); #1;
        chk(out_vld == v, {tag, " out_vld R2"}, 64'(out_vld), 64'(v));
        chk(res_wr == (v && erw), {tag, " res_wr R9"}, 64'(res_wr), 64'(v && erw));
        chk(cr_wr == (v && ecw), {tag, " cr_wr R8"}, 64'(cr_wr), 64'(v && ecw));
        if (v) begin
            chk(out_op == op && out_insn == ins, {tag, " ctx R2"}, {29'h0, out_op, out_insn}, {29'h0, op, ins});
            chk(res_out == eres, {tag, " res"}, res_out, eres);
            chk(cr_out == ecr, {tag, " cr"}, 64'(cr_out), 64'(ecr));
        end
    endtask

    initial begin
        #1_000_000;
        if (!done) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog expired R2 actual=%0d expected=%0d", 0, 1);
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        logic [31:0] ins;
        rst_n = 0; in_vld = 1; op_in = 3'd2; insn_in = 0; gpr_in = 0; cr_in = 32'hFFFF_FFFF;
        repeat (3) @(posedge clk);
        #1;
        chk(!out_vld && !res_wr && !cr_wr, "reset R1", {61'h0, out_vld, res_wr, cr_wr}, 64'h0);
        @(negedge clk); rst_n = 1;

        // R3 move in
        step(1, 3'd1, 32'h0, 32'hAAAA_5555, 32'h1234_5678, "mtcr empty R3");
        step(1, 3'd1, 32'hFF << 12, 32'hAAAA_5555, 32'h1234_5678, "mtcr full R3");
        step(1, 3'd1, 32'h81 << 12, 32'hDEAD_BEEF, 32'h1234_5678, "mtcr ends R3");
        // R4 / R5 move out
        step(1, 3'd2, 32'h0, 32'h0, 32'h8765_4321, "mfcr whole R4");
        step(1, 3'd2, 32'h00A5_0000 >> 4 | 32'h0010_0000, 32'h0, 32'hFEDC_BA98, "mfcr one R5");
        step(1, 3'd2, 32'h0010_0000, 32'h0, 32'hFEDC_BA98, "mfcr none R5");
        // R6 field copy: dest 0 (top field) from source 7 (bottom field)
        step(1, 3'd3, (32'd0 << 23) | (32'd7 << 18), 32'h0, 32'h1234_5678, "fcopy top R6");
        step(1, 3'd3, (32'd7 << 23) | (32'd0 << 18), 32'h0, 32'h1234_5678, "fcopy bot R6");
        step(1, 3'd3, (32'd3 << 23) | (32'd3 << 18), 32'h0, 32'h1234_5678, "fcopy self R6");
        // R7 bit op: BT=0 (MSB), AND table 4'b1000
        step(1, 3'd4, (32'd0 << 21) | (32'd31 << 16) | (32'd30 << 11) | (32'h8 << 6), 32'h0, 32'h0000_0003, "bitop and R7");
        step(1, 3'd4, (32'd31 << 21) | (32'd0 << 16) | (32'd0 << 11) | (32'h6 << 6), 32'h0, 32'h8000_0001, "bitop xor R7");
        // R8 unknown opcodes and idle
        step(1, 3'd0, 32'hFFFF_FFFF, 32'h0, 32'hCAFE_F00D, "op0 R8");
        step(1, 3'd5, 32'hFFFF_FFFF, 32'h0, 32'hCAFE_F00D, "op5 R8");
        step(1, 3'd6, 32'hFFFF_FFFF, 32'h0, 32'hCAFE_F00D, "op6 R8");
        step(1, 3'd7, 32'hFFFF_FFFF, 32'h0, 32'hCAFE_F00D, "op7 R8");
        step(0, 3'd1, 32'hFF << 12, 32'h1111_1111, 32'h0, "idle mtcr R8");
        step(0, 3'd2, 32'h0, 32'h0, 32'h1, "idle mfcr R8");

        // random mix, R9 flag exclusivity checked on every step
        for (int n = 0; n < 400; n++) begin
            ins = $urandom;
            step(($urandom % 8) != 0, 3'($urandom % 8), ins, $urandom, $urandom, "random R9");
        end

        done = 1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule